// File: doc/BRIEF.md
# Serial Command-Mode Memory Interface

This block is a synchronous serial front end for a small byte-wide memory driven in command mode. A host supplies a serial clock and a data bit, together with two level inputs: one picks a data transfer or a command transfer, the other picks read or write. Bits are gathered MSB first in an eight-bit shifter. On every eighth rising clock edge the shifter trades its contents with the address pointer, the memory or an XOR checksum register. The data output always shows the shifter's top bit while the device is selected. A write stream therefore passes through the device eight clocks late, and several devices can share one serial loop in a chain with only one of them selected.

A transfer starts by writing the pointer as command bytes, lowest byte first. Data bytes are then written or read, and the pointer steps by one after each. A read copies its byte into the shifter on the eighth edge, and that byte is shifted out during the next byte time. The first byte of a read burst is therefore a dummy. Reading the checksum register shows the XOR of every data byte moved since the last command write. All pins are sampled through a synchronizer running on a faster system clock, and serial clock edges are found there.

Top module: `ser_cmdmem_if`

## Requirements
- R1: The block responds only while ser_mode_n is 0, cs_hi is 1 and cs_lo_n is 0. At any other time sdo is 0, and serial clock edges change neither the shifter, the pointer, the checksum nor the memory.
- R2: Each rising serial clock edge shifts sdi into the shifter LSB, so bytes arrive MSB first. While selected, sdo shows the shifter MSB. After a write byte, the shifter holds that byte, so a write stream reappears on sdo eight clocks later.
- R3: A command write (dat_cmd=0, rd_wrn=0) stores its byte into pointer byte 0, 1, then 2, and the fourth command write wraps back to byte 0. Every command write clears the checksum to 0.
- R4: Any data transfer (dat_cmd=1) and any deselection returns the pointer-byte rotation to byte 0.
- R5: A data write (dat_cmd=1, rd_wrn=0) stores the byte at the memory index given by the pointer's low MEM_AW bits. It then adds one to the pointer and XORs the byte into the checksum.
- R6: With rd_wrn=1, the eighth edge loads the shifter with the checksum (dat_cmd=0) or with the memory byte at the pointer (dat_cmd=1). That byte appears on sdo MSB first during the following eight clocks, so a read burst is one byte late.
- R7: A data read adds one to the pointer and XORs the byte read into the checksum. A checksum read changes neither the pointer nor the checksum.
- R8: Deselection clears the bit counter, so a partial byte is dropped and framing restarts on the next selection.
- R9: Reset clears the pointer, checksum, shifter, bit counter, rotation and all memory bytes to 0.
- R10: When the memory index is all ones, a pointer step wraps the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode_n | input | 1 | Low enables the serial interface |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| dat_cmd | input | 1 | 1 = memory data, 0 = pointer/checksum |
| rd_wrn | input | 1 | 1 = read, 0 = write |
| sclk | input | 1 | Serial clock, sampled on clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, shifter MSB while selected |

## Verification
The assertions assume that each serial clock phase lasts longer than the synchronizer delay, so that every rising edge yields exactly one detected edge. They also assume that sdi, dat_cmd and rd_wrn do not change in the cycles around a rising edge. The stimulus holds each serial clock phase for four system clocks and changes data, mode and select inputs only at the start of a low phase. It samples sdo just before each rising edge. The expected sdo bytes come from the requirement rules alone: the byte shifted in before, or the byte loaded at the last boundary.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    localparam int BYTE_W = 8;

    // Raw pin bundle carried through the synchronizer.
    typedef struct packed {
        logic mode_n;
        logic cs_lo_n;
        logic cs_hi;
        logic dc;
        logic rw;
        logic sclk;
        logic sdi;
    } pin_s;

    // Encoding is {dat_cmd, rd_wrn}.
    typedef enum logic [1:0] {
        OP_CMD_WR = 2'b00,
        OP_CKS_RD = 2'b01,
        OP_DAT_WR = 2'b10,
        OP_DAT_RD = 2'b11
    } op_e;

endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync
    import sermem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  pin_s pins_i,
    output logic sel_o,
    output logic dc_o,
    output logic rw_o,
    output logic sdi_o,
    output logic rise_o
);

    typedef struct packed {
        pin_s [STAGES-1:0] pipe;
        logic              sclk_prev;
    } sync_s;

    sync_s st_d, st_q;
    pin_s  last;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.sclk_prev = st_q.pipe[STAGES-1].sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last   = st_q.pipe[STAGES-1];
    assign sel_o  = ~last.mode_n & last.cs_hi & ~last.cs_lo_n;
    assign dc_o   = last.dc;
    assign rw_o   = last.rw;
    assign sdi_o  = last.sdi;
    assign rise_o = last.sclk & ~st_q.sclk_prev;

    // A detected edge is never followed directly by another one.
    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R2

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         sel_i,
    input  logic         sdi_i,
    input  logic         rd_i,
    input  logic [W-1:0] load_i,
    output logic         done_o,
    output logic [W-1:0] byte_o,
    output logic         sdo_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [W-1:0]     sh;
        logic [CNT_W-1:0] cnt;
    } shf_s;

    shf_s st_d, st_q;

    assign byte_o = {st_q.sh[W-2:0], sdi_i};
    assign done_o = rise_i & sel_i & (st_q.cnt == LAST);
    assign sdo_o  = sel_i & st_q.sh[W-1];

    always_comb begin
        st_d = st_q;
        if (!sel_i) begin
            st_d.cnt = '0;
        end else if (rise_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.sh  = rd_i ? load_i : byte_o;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.sh  = byte_o;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DESEL_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> st_q.cnt == '0);  // R8

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && sel_i && st_q.cnt != LAST) |=>
            st_q.sh == {$past(st_q.sh[W-2:0]), $past(sdi_i)});  // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i || !sel_i) |=> $stable(st_q.sh));  // R1

endmodule

// File: rtl/ser_byte_mem.sv
module ser_byte_mem #(
    parameter int AW = 8,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];

    assign rdata_o = mem_q[addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

endmodule

// File: rtl/ser_cmdmem_if.sv
module ser_cmdmem_if
    import sermem_pkg::*;
#(
    parameter int PTR_BYTES   = 3,
    parameter int MEM_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_mode_n,
    input  logic cs_lo_n,
    input  logic cs_hi,
    input  logic dat_cmd,
    input  logic rd_wrn,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);

    localparam int PTR_W = PTR_BYTES * BYTE_W;
    localparam int ROT_W = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] cks;
        logic [ROT_W-1:0]  rot;
    } ctl_s;

    ctl_s st_d, st_q;

    pin_s              pins;
    logic              sel, dc_s, rw_s, sdi_s, rise;
    logic              done;
    logic [BYTE_W-1:0] byte_v, load_v, mem_rd;
    logic              mem_we;
    op_e               op;

    assign pins = '{mode_n: ser_mode_n, cs_lo_n: cs_lo_n, cs_hi: cs_hi,
                    dc: dat_cmd, rw: rd_wrn, sclk: sclk, sdi: sdi};

    ser_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .sel_o  (sel),
        .dc_o   (dc_s),
        .rw_o   (rw_s),
        .sdi_o  (sdi_s),
        .rise_o (rise)
    );

    assign load_v = dc_s ? mem_rd : st_q.cks;

    ser_shifter #(.W(BYTE_W)) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .sel_i  (sel),
        .sdi_i  (sdi_s),
        .rd_i   (rw_s),
        .load_i (load_v),
        .done_o (done),
        .byte_o (byte_v),
        .sdo_o  (sdo)
    );

    ser_byte_mem #(.AW(MEM_AW), .W(BYTE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .addr_i  (st_q.ptr[MEM_AW-1:0]),
        .wdata_i (byte_v),
        .rdata_o (mem_rd)
    );

    assign op = op_e'({dc_s, rw_s});

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (!sel) begin
            st_d.rot = '0;
        end else if (done) begin
            unique case (op)
                OP_CMD_WR: begin
                    for (int b = 0; b < PTR_BYTES; b++) begin
                        if (int'(st_q.rot) == b) st_d.ptr[b*BYTE_W +: BYTE_W] = byte_v;
                    end
                    st_d.rot = (int'(st_q.rot) == PTR_BYTES - 1) ? '0 : st_q.rot + ROT_W'(1);
                    st_d.cks = '0;
                end
                OP_DAT_WR: begin
                    mem_we   = 1'b1;
                    st_d.ptr = st_q.ptr + PTR_W'(1);
                    st_d.cks = st_q.cks ^ byte_v;
                    st_d.rot = '0;
                end
                OP_DAT_RD: begin
                    st_d.ptr = st_q.ptr + PTR_W'(1);
                    st_d.cks = st_q.cks ^ mem_rd;
                    st_d.rot = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CMD_CLEARS_CKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_CMD_WR) |=> st_q.cks == '0);  // R3

    AST_ROT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.rot) < PTR_BYTES);  // R3

    AST_DATA_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dc_s) |=> st_q.rot == '0);  // R4

    AST_DESEL_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> st_q.rot == '0);  // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dc_s) |=> st_q.ptr == $past(st_q.ptr) + PTR_W'(1));  // R5

    AST_CKS_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_CKS_RD) |=> ($stable(st_q.cks) && $stable(st_q.ptr)));  // R7

    AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(st_q.ptr) && $stable(st_q.cks)));  // R1

    AST_WE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sel && rise));  // R1

endmodule

// File: tb/ser_cmdmem_if_test.sv
module ser_cmdmem_if_test;

    localparam int HALF = 4;
    localparam int NV   = 38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_mode_n = 1'b0;
    logic cs_lo_n = 1'b1;
    logic cs_hi = 1'b0;
    logic dat_cmd = 1'b0;
    logic rd_wrn = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ser_cmdmem_if uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_mode_n (ser_mode_n),
        .cs_lo_n    (cs_lo_n),
        .cs_hi      (cs_hi),
        .dat_cmd    (dat_cmd),
        .rd_wrn     (rd_wrn),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo)
    );

    // Row: {dat_cmd, rd_wrn, byte sent, byte expected on sdo, requirement}
    localparam logic [21:0] VEC [NV] = '{
        {2'b00, 8'h10, 8'h00, 4'd9},  // R9 shifter starts at 0
        {2'b00, 8'h00, 8'h10, 4'd2},  // R2 write stream echoed
        {2'b00, 8'h00, 8'h00, 4'd2},
        {2'b10, 8'hA5, 8'h00, 4'd2},
        {2'b10, 8'h3C, 8'hA5, 4'd2},
        {2'b10, 8'h7E, 8'h3C, 4'd2},
        {2'b10, 8'h01, 8'h7E, 4'd2},
        {2'b00, 8'h10, 8'h01, 4'd4},  // R4 rotation back at byte 0
        {2'b00, 8'h00, 8'h10, 4'd3},
        {2'b00, 8'h00, 8'h00, 4'd3},
        {2'b11, 8'h00, 8'h00, 4'd6},  // R6 dummy byte
        {2'b11, 8'h00, 8'hA5, 4'd5},  // R5 stored at pointer
        {2'b11, 8'h00, 8'h3C, 4'd6},
        {2'b11, 8'h00, 8'h7E, 4'd6},
        {2'b01, 8'h00, 8'h01, 4'd6},
        {2'b01, 8'h00, 8'hE6, 4'd7},  // R7 XOR of reads
        {2'b01, 8'h00, 8'hE6, 4'd7},  // R7 checksum read leaves it
        {2'b00, 8'h10, 8'hE6, 4'd7},
        {2'b01, 8'h00, 8'h10, 4'd3},
        {2'b01, 8'h00, 8'h00, 4'd3},  // R3 cleared by command
        {2'b11, 8'h00, 8'h00, 4'd6},
        {2'b00, 8'h20, 8'hA5, 4'd6},
        {2'b00, 8'h00, 8'h20, 4'd3},
        {2'b00, 8'h00, 8'h00, 4'd3},
        {2'b00, 8'h30, 8'h00, 4'd3},  // R3 fourth write wraps
        {2'b10, 8'h99, 8'h30, 4'd3},
        {2'b00, 8'h30, 8'h99, 4'd3},
        {2'b00, 8'h00, 8'h30, 4'd3},
        {2'b00, 8'h00, 8'h00, 4'd3},
        {2'b11, 8'h00, 8'h00, 4'd6},
        {2'b11, 8'h00, 8'h99, 4'd3},
        {2'b01, 8'h00, 8'h00, 4'd6},
        {2'b01, 8'h00, 8'h99, 4'd7},
        {2'b00, 8'h50, 8'h99, 4'd7},
        {2'b10, 8'h0F, 8'h50, 4'd5},
        {2'b10, 8'hF0, 8'h0F, 4'd5},
        {2'b01, 8'h00, 8'hF0, 4'd5},
        {2'b01, 8'h00, 8'hFF, 4'd5}   // R5 XOR of writes
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic one_bit(input logic b, output logic s);
        sdi  = b;
        sclk = 1'b0;
        wait_clk(HALF);
        s    = sdo;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic xfer(input logic dc, input logic rw, input logic [7:0] tx,
                        output logic [7:0] rx);
        dat_cmd = dc;
        rd_wrn  = rw;
        for (int i = 7; i >= 0; i--) begin
            logic s;
            one_bit(tx[i], s);
            rx[i] = s;
        end
    endtask

    task automatic select(input logic on);
        sclk  = 1'b0;
        cs_hi = on;
        cs_lo_n = ~on;
        wait_clk(2 * HALF);
    endtask

    task automatic do_chk(input logic dc, input logic rw, input logic [7:0] tx,
                          input logic [7:0] exp, input string req);
        logic [7:0] rx;
        xfer(dc, rw, tx, rx);
        check(req, rx, exp);
    endtask

    initial begin
        wait_clk(200000);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic       s;
        wait_clk(3);
        check("R9", {7'd0, sdo}, 8'h00);
        rst_n = 1'b1;
        wait_clk(2);
        select(1'b1);
        check("R9", {7'd0, sdo}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            xfer(VEC[v][21], VEC[v][20], VEC[v][19:12], rx);
            check($sformatf("R%0d", VEC[v][3:0]), rx, VEC[v][11:4]);
        end

        // R1: edges while deselected or in the other mode are ignored
        do_chk(1'b0, 1'b0, 8'h30, 8'hFF, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h30, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h00, "R2");
        select(1'b0);
        do_chk(1'b1, 1'b0, 8'hFF, 8'h00, "R1");
        ser_mode_n = 1'b1;
        select(1'b1);
        do_chk(1'b1, 1'b0, 8'hFF, 8'h00, "R1");
        ser_mode_n = 1'b0;
        select(1'b0);
        select(1'b1);
        do_chk(1'b1, 1'b1, 8'h00, 8'h00, "R1");
        do_chk(1'b1, 1'b1, 8'h00, 8'h99, "R1");

        // R8: partial byte dropped by deselection
        dat_cmd = 1'b0;
        rd_wrn  = 1'b0;
        for (int k = 0; k < 3; k++) one_bit(1'b1, s);
        select(1'b0);
        select(1'b1);
        do_chk(1'b0, 1'b0, 8'h40, 8'h07, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h40, "R8");
        do_chk(1'b0, 1'b0, 8'h00, 8'h00, "R8");
        do_chk(1'b1, 1'b0, 8'h5A, 8'h00, "R8");
        do_chk(1'b0, 1'b0, 8'h40, 8'h5A, "R8");
        do_chk(1'b0, 1'b0, 8'h00, 8'h40, "R4");
        do_chk(1'b0, 1'b0, 8'h00, 8'h00, "R4");
        do_chk(1'b1, 1'b1, 8'h00, 8'h00, "R6");
        do_chk(1'b1, 1'b1, 8'h00, 8'h5A, "R8");

        // R10: index wraps from all ones to zero
        do_chk(1'b0, 1'b0, 8'hFF, 8'h00, "R6");
        do_chk(1'b0, 1'b0, 8'h00, 8'hFF, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h00, "R2");
        do_chk(1'b1, 1'b0, 8'h11, 8'h00, "R2");
        do_chk(1'b1, 1'b0, 8'h22, 8'h11, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h22, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h00, "R2");
        do_chk(1'b0, 1'b0, 8'h00, 8'h00, "R2");
        do_chk(1'b1, 1'b1, 8'h00, 8'h00, "R6");
        do_chk(1'b1, 1'b1, 8'h00, 8'h22, "R10");

        // R9: reset clears memory, pointer and checksum
        select(1'b0);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        select(1'b1);
        do_chk(1'b0, 1'b1, 8'h00, 8'h00, "R9");
        do_chk(1'b1, 1'b1, 8'h00, 8'h00, "R9");
        do_chk(1'b1, 1'b1, 8'h00, 8'h00, "R9");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule